// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block is the hazard-control slice of a five-stage, in-order, 32-bit integer pipeline. It takes the decoded register usage of the instruction in the decode stage and carries a slim copy of it through its own shadow of the execute, memory and writeback pipeline registers. From that shadow it computes, in the execute stage, a 2-bit select code for a 4:1 multiplexer in front of each ALU operand. Each multiplexer picks the register file value (or the immediate, for operand B), the ALU result waiting in the EX/MEM register, or the value waiting in the MEM/WB register.

Forwarding cannot cover a read that directly follows a load to the same register, because the load data is not ready in time. The other hazard comes from link-type instructions: such an instruction in decode competes for the single register-file write port with whatever instruction in writeback is writing. The decode-stage detector covers both cases with one interlock. It holds the PC and the IF/ID register, and it inserts a bubble into the execute stage. The surrounding pipeline refetches, and the held instruction proceeds once the condition is gone. The ALU datapath, the memories and the register file sit outside this block.

Top module: `fwd_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it with no-operation input, both select codes read 00 and the PC hold, IF/ID hold and bubble outputs are all low.
- R2: Select codes are 00 = register file, 01 = EX/MEM result, 10 = MEM/WB value. Operand A takes 01 when its source is used and equals a writing, non-zero EX/MEM destination.
- R3: Operand A takes 10 when only the MEM/WB stage holds a writing, non-zero destination equal to its used source.
- R4: When both the EX/MEM and the MEM/WB stage write the register that an operand reads, the younger EX/MEM value wins and the code is 01.
- R5: A source of register 0, an unused source, or a matching stage whose write enable is low always yields code 00.
- R6: Operand B follows the same rules on its own source, except that when the instruction takes the immediate on B the code is forced to 00.
- R7: A used source in decode that equals the non-zero destination of a writing load in execute raises pc_hold_o, ifid_hold_o and bubble_o for exactly one cycle while decode is held. Two cycles later the reader sits in execute with code 10.
- R8: A non-load producer in execute causes no stall, and the dependent instruction next cycle receives code 01. A load to register 0, or a load whose destination the decode instruction does not read, also causes no stall.
- R9: A link instruction in decode stalls on every cycle in which the writeback stage has its write enable set, and proceeds on the first cycle in which it does not.
- R10: The cycle after a stall, the execute stage holds a bubble that writes nothing and reads nothing. The held decode instruction is not captured twice, so no operand forwards from the bubble.
- R11: The select code 11 never appears on either operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_src_a_i | input | 5 | Decode-stage source register for ALU operand A |
| id_src_b_i | input | 5 | Decode-stage source register for ALU operand B |
| id_a_used_i | input | 1 | Decode instruction reads source A |
| id_b_used_i | input | 1 | Decode instruction reads source B |
| id_b_imm_i | input | 1 | Decode instruction feeds the immediate to operand B |
| id_dst_i | input | 5 | Decode-stage destination register |
| id_wr_i | input | 1 | Decode instruction writes its destination |
| id_is_load_i | input | 1 | Decode instruction is a load |
| id_is_link_i | input | 1 | Decode instruction is a link-type jump or branch |
| sel_a_o | output | 2 | Operand A multiplexer select |
| sel_b_o | output | 2 | Operand B multiplexer select |
| pc_hold_o | output | 1 | Hold the program counter (refetch) |
| ifid_hold_o | output | 1 | Hold the IF/ID pipeline register |
| bubble_o | output | 1 | Insert a no-operation into execute |

## Verification
On every cycle the assertions check the select rules against the shadow stage contents. They cover EX/MEM priority, the fallback to MEM/WB, the register-0 and immediate overrides, the unused code 11, and the empty stage that follows every bubble. The bench scenarios are needed for the behaviour that spans an instruction sequence. They count exactly one bubble per load-use pair, confirm that the reader then receives the MEM/WB code, and count two bubbles when two writers pass through writeback ahead of a link instruction. They also check the non-stall cases of a load to register 0 and of a reader that does not use the loaded register.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  parameter int unsigned REG_W = 5;
  localparam int unsigned LATE_STAGES = 2;  // EX/MEM, MEM/WB

  typedef logic [REG_W-1:0] reg_id_t;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_EXM = 2'b01,
    SEL_MWB = 2'b10
  } fwd_sel_e;

  // Full control word held in ID/EX
  typedef struct packed {
    reg_id_t src_a;
    reg_id_t src_b;
    logic    a_used;
    logic    b_used;
    logic    b_imm;
    reg_id_t dst;
    logic    wr;
    logic    is_load;
  } ex_ctl_t;

  // Write-side view kept past EX
  typedef struct packed {
    reg_id_t dst;
    logic    wr;
  } wb_ctl_t;
endpackage

// File: rtl/fwd_pipe.sv
module fwd_pipe
  import fwd_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  ex_ctl_t                    id_i,
  input  logic                       flush_i,
  output ex_ctl_t                    ex_o,
  output wb_ctl_t [LATE_STAGES-1:0]  late_o
);
  ex_ctl_t ex_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ex_q <= '0;
    else if (flush_i) ex_q <= '0;
    else              ex_q <= id_i;
  end

  assign ex_o = ex_q;

  for (genvar g = 0; g < LATE_STAGES; g++) begin : g_late
    wb_ctl_t q;
    wb_ctl_t d;
    if (g == 0) begin : g_first
      assign d = '{dst: ex_q.dst, wr: ex_q.wr};
    end else begin : g_next
      assign d = g_late[g-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end
    assign late_o[g] = q;
  end
endmodule

// File: rtl/fwd_sel.sv
module fwd_sel
  import fwd_pkg::*;
(
  input  reg_id_t  src_i,
  input  logic     used_i,
  input  logic     imm_i,
  input  reg_id_t  exm_dst_i,
  input  logic     exm_wr_i,
  input  reg_id_t  mwb_dst_i,
  input  logic     mwb_wr_i,
  output fwd_sel_e sel_o
);
  logic live;
  logic hit_exm;
  logic hit_mwb;

  assign live    = used_i && !imm_i && (src_i != '0);
  assign hit_exm = live && exm_wr_i && (exm_dst_i == src_i);
  assign hit_mwb = live && mwb_wr_i && (mwb_dst_i == src_i);

  always_comb begin
    if (hit_exm)      sel_o = SEL_EXM;  // younger result first
    else if (hit_mwb) sel_o = SEL_MWB;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_hazard.sv
module fwd_hazard
  import fwd_pkg::*;
(
  input  ex_ctl_t id_i,
  input  logic    id_is_link_i,
  input  ex_ctl_t ex_i,
  input  logic    wb_wr_i,
  output logic    stall_o
);
  logic load_live;
  logic rd_a;
  logic rd_b;
  logic load_use;
  logic link_clash;

  assign load_live  = ex_i.is_load && ex_i.wr && (ex_i.dst != '0);
  assign rd_a       = id_i.a_used && (id_i.src_a == ex_i.dst);
  assign rd_b       = id_i.b_used && (id_i.src_b == ex_i.dst);
  assign load_use   = load_live && (rd_a || rd_b);
  assign link_clash = id_is_link_i && wb_wr_i;
  assign stall_o    = load_use || link_clash;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_src_a_i,
  input  logic [REG_W-1:0] id_src_b_i,
  input  logic             id_a_used_i,
  input  logic             id_b_used_i,
  input  logic             id_b_imm_i,
  input  logic [REG_W-1:0] id_dst_i,
  input  logic             id_wr_i,
  input  logic             id_is_load_i,
  input  logic             id_is_link_i,
  output logic [1:0]       sel_a_o,
  output logic [1:0]       sel_b_o,
  output logic             pc_hold_o,
  output logic             ifid_hold_o,
  output logic             bubble_o
);
  localparam int unsigned N_OPS = 2;

  ex_ctl_t                   id_ctl;
  ex_ctl_t                   ex_q;
  wb_ctl_t [LATE_STAGES-1:0] late_q;
  logic                      stall;

  reg_id_t  op_src  [N_OPS];
  logic     op_used [N_OPS];
  logic     op_imm  [N_OPS];
  fwd_sel_e op_sel  [N_OPS];

  assign id_ctl = '{
    src_a:   id_src_a_i,
    src_b:   id_src_b_i,
    a_used:  id_a_used_i,
    b_used:  id_b_used_i,
    b_imm:   id_b_imm_i,
    dst:     id_dst_i,
    wr:      id_wr_i,
    is_load: id_is_load_i
  };

  fwd_hazard u_hazard (
    .id_i         (id_ctl),
    .id_is_link_i (id_is_link_i),
    .ex_i         (ex_q),
    .wb_wr_i      (late_q[LATE_STAGES-1].wr),
    .stall_o      (stall)
  );

  fwd_pipe u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .id_i    (id_ctl),
    .flush_i (stall),
    .ex_o    (ex_q),
    .late_o  (late_q)
  );

  assign op_src[0]  = ex_q.src_a;
  assign op_used[0] = ex_q.a_used;
  assign op_imm[0]  = 1'b0;
  assign op_src[1]  = ex_q.src_b;
  assign op_used[1] = ex_q.b_used;
  assign op_imm[1]  = ex_q.b_imm;

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    fwd_sel u_sel (
      .src_i     (op_src[k]),
      .used_i    (op_used[k]),
      .imm_i     (op_imm[k]),
      .exm_dst_i (late_q[0].dst),
      .exm_wr_i  (late_q[0].wr),
      .mwb_dst_i (late_q[1].dst),
      .mwb_wr_i  (late_q[1].wr),
      .sel_o     (op_sel[k])
    );
  end

  assign sel_a_o     = op_sel[0];
  assign sel_b_o     = op_sel[1];
  assign pc_hold_o   = stall;
  assign ifid_hold_o = stall;
  assign bubble_o    = stall;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
  import fwd_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [1:0]                sel_a_o,
  input logic [1:0]                sel_b_o,
  input logic                      bubble_o,
  input ex_ctl_t                   ex_q,
  input wb_ctl_t [LATE_STAGES-1:0] late_q
);
  logic a_exm, a_mwb;
  assign a_exm = ex_q.a_used && (ex_q.src_a != '0) && late_q[0].wr && (late_q[0].dst == ex_q.src_a);
  assign a_mwb = ex_q.a_used && (ex_q.src_a != '0) && late_q[1].wr && (late_q[1].dst == ex_q.src_a);

  // R2, R4
  a_r4_exm_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_exm |-> sel_a_o == 2'b01);

  // R3
  a_r3_mwb_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mwb && !a_exm) |-> sel_a_o == 2'b10);

  // R5
  a_r5_zero_or_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_o != 2'b00) |-> (ex_q.a_used && ex_q.src_a != '0));

  // R6
  a_r6_imm_forces_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_q.b_imm |-> sel_b_o == 2'b00);

  // R10
  a_r10_bubble_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |=> (!ex_q.wr && !ex_q.a_used && !ex_q.b_used && !ex_q.is_load));

  // R11
  a_r11_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_o != 2'b11) && (sel_b_o != 2'b11));
endmodule

bind fwd_unit fwd_unit_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_a_o  (sel_a_o),
  .sel_b_o  (sel_b_o),
  .bubble_o (bubble_o),
  .ex_q     (ex_q),
  .late_q   (late_q)
);

// File: tb/fwd_unit_test.sv
`timescale 1ns/1ps
module fwd_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] id_src_a_i, id_src_b_i, id_dst_i;
  logic       id_a_used_i, id_b_used_i, id_b_imm_i, id_wr_i, id_is_load_i, id_is_link_i;
  logic [1:0] sel_a_o, sel_b_o;
  logic       pc_hold_o, ifid_hold_o, bubble_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fwd_unit uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [4:0] a, input logic [4:0] b, input logic au, input logic bu,
                     input logic imm, input logic [4:0] d, input logic wr, input logic ld,
                     input logic lnk);
    id_src_a_i = a; id_src_b_i = b; id_a_used_i = au; id_b_used_i = bu; id_b_imm_i = imm;
    id_dst_i = d; id_wr_i = wr; id_is_load_i = ld; id_is_link_i = lnk;
  endtask

  task automatic nop();
    put(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic adv();
    @(negedge clk_i);
  endtask

  task automatic stall_is(input string tag, input logic exp);
    chk({tag, " pc_hold"}, pc_hold_o, exp);
    chk({tag, " ifid_hold"}, ifid_hold_o, exp);
    chk({tag, " bubble"}, bubble_o, exp);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) begin adv(); nop(); end
  endtask

  task automatic t_reset();
    nop();
    #22;
    chk("R1 sel_a in reset", sel_a_o, 0);
    chk("R1 sel_b in reset", sel_b_o, 0);
    stall_is("R1 in reset", 1'b0);
    adv(); rst_ni = 1'b1;
    adv(); #1;
    chk("R1 sel_a after reset", sel_a_o, 0);
    stall_is("R1 after reset", 1'b0);
  endtask

  task automatic t_exm();
    drain();
    adv(); put(0, 0, 0, 0, 0, 5, 1, 0, 0);
    adv(); put(5, 0, 1, 0, 0, 0, 0, 0, 0);
    #1 stall_is("R8 alu producer", 1'b0);
    adv(); nop(); #1;
    chk("R2 sel_a from EX/MEM", sel_a_o, 1);
  endtask

  task automatic t_mwb();
    drain();
    adv(); put(0, 0, 0, 0, 0, 6, 1, 0, 0);
    adv(); nop();
    adv(); put(6, 0, 1, 0, 0, 0, 0, 0, 0);
    adv(); nop(); #1;
    chk("R3 sel_a from MEM/WB", sel_a_o, 2);
  endtask

  task automatic t_priority();
    drain();
    adv(); put(0, 0, 0, 0, 0, 5, 1, 0, 0);
    adv(); put(0, 0, 0, 0, 0, 5, 1, 0, 0);
    adv(); put(5, 5, 1, 1, 0, 0, 0, 0, 0);
    adv(); nop(); #1;
    chk("R4 sel_a younger wins", sel_a_o, 1);
    chk("R4 sel_b younger wins", sel_b_o, 1);
  endtask

  task automatic t_zero();
    drain();
    adv(); put(0, 0, 0, 0, 0, 0, 1, 0, 0);
    adv(); put(0, 0, 1, 0, 0, 0, 0, 0, 0);
    adv(); nop(); #1;
    chk("R5 register 0", sel_a_o, 0);
    drain();
    adv(); put(0, 0, 0, 0, 0, 5, 0, 0, 0);
    adv(); put(5, 0, 1, 0, 0, 0, 0, 0, 0);
    adv(); nop(); #1;
    chk("R5 write enable low", sel_a_o, 0);
    drain();
    adv(); put(0, 0, 0, 0, 0, 5, 1, 0, 0);
    adv(); put(5, 0, 0, 0, 0, 0, 0, 0, 0);
    adv(); nop(); #1;
    chk("R5 source unused", sel_a_o, 0);
  endtask

  task automatic t_b();
    drain();
    adv(); put(0, 0, 0, 0, 0, 4, 1, 0, 0);
    adv(); put(0, 4, 0, 1, 0, 0, 0, 0, 0);
    adv(); nop(); #1;
    chk("R6 sel_b from EX/MEM", sel_b_o, 1);
    drain();
    adv(); put(0, 0, 0, 0, 0, 4, 1, 0, 0);
    adv(); put(0, 4, 0, 1, 1, 0, 0, 0, 0);
    adv(); nop(); #1;
    chk("R6 immediate forces 00", sel_b_o, 0);
    drain();
    adv(); put(0, 0, 0, 0, 0, 4, 1, 0, 0);
    adv(); nop();
    adv(); put(0, 4, 0, 1, 0, 0, 0, 0, 0);
    adv(); nop(); #1;
    chk("R6 sel_b from MEM/WB", sel_b_o, 2);
  endtask

  task automatic t_load_use();
    int bubbles = 0;
    drain();
    adv(); put(0, 0, 0, 0, 0, 7, 1, 1, 0);
    adv(); put(7, 0, 1, 0, 0, 8, 1, 0, 0);
    #1 stall_is("R7 load-use detect", 1'b1);
    bubbles += int'(bubble_o);
    adv(); #1;  // decode held
    stall_is("R7 stall released", 1'b0);
    bubbles += int'(bubble_o);
    chk("R10 no forward from bubble", sel_a_o, 0);
    adv(); nop(); #1;
    bubbles += int'(bubble_o);
    chk("R7 reader gets MEM/WB", sel_a_o, 2);
    chk("R7 exactly one bubble", bubbles, 1);
    drain();
    adv(); put(0, 0, 0, 0, 0, 9, 1, 1, 0);
    adv(); put(0, 9, 0, 1, 0, 0, 0, 0, 0);
    #1 chk("R7 load-use on B", bubble_o, 1);
  endtask

  task automatic t_no_stall();
    drain();
    adv(); put(0, 0, 0, 0, 0, 0, 1, 1, 0);
    adv(); put(0, 0, 1, 0, 0, 0, 0, 0, 0);
    #1 chk("R8 load to r0", bubble_o, 0);
    drain();
    adv(); put(0, 0, 0, 0, 0, 7, 1, 1, 0);
    adv(); put(7, 7, 0, 0, 0, 0, 0, 0, 0);
    #1 chk("R8 register not read", bubble_o, 0);
  endtask

  task automatic t_link();
    int bubbles = 0;
    drain();
    adv(); put(0, 0, 0, 0, 0, 3, 1, 0, 0);
    adv(); nop();
    adv(); nop();
    adv(); put(0, 0, 0, 0, 0, 31, 1, 0, 1);
    #1 stall_is("R9 link vs WB write", 1'b1);
    adv(); #1;
    stall_is("R9 link proceeds", 1'b0);
    drain();
    adv(); put(0, 0, 0, 0, 0, 3, 1, 0, 0);
    adv(); put(0, 0, 0, 0, 0, 4, 1, 0, 0);
    adv(); nop();
    adv(); put(0, 0, 0, 0, 0, 31, 1, 0, 1);
    for (int i = 0; i < 3; i++) begin
      #1 bubbles += int'(bubble_o);
      adv();
    end
    chk("R9 two writers two bubbles", bubbles, 2);
    drain();
    adv(); put(0, 0, 0, 0, 0, 31, 1, 0, 1);
    #1 chk("R9 link without writer", bubble_o, 0);
  endtask

  initial begin
    t_reset();
    t_exm();
    t_mwb();
    t_priority();
    t_zero();
    t_b();
    t_load_use();
    t_no_stall();
    t_link();
    chk("R11 code 3 unused A", int'(sel_a_o == 2'b11), 0);
    chk("R11 code 3 unused B", int'(sel_b_o == 2'b11), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule